// File: doc/BRIEF.md
# Quad 12-bit Converter Register Front End

This block holds the digital codes for four 12-bit converter channels that share one 8-bit parallel load port. Each channel's code is built from two pieces written at separate addresses: a low byte and a high nibble. The pieces collect in a first rank of input registers. A shared latch-enable control then copies all four input registers into a second rank at once. The second rank drives the channel codes. When the write strobe is also held active, latch enable makes that second rank transparent.

The bus strobes arrive asynchronously. They are resynchronised to the system clock before any register uses them. An active-low asynchronous clear empties the input rank and parks every output code at mid-scale, which is the zero point of the offset-binary code space. A one-cycle update strobe marks every clock on which the output codes move, so that downstream logic can tell that all four channels moved together.

Top module: `quad_dac_frontend`

## Requirements
- R1: A write at address `{ch,0}` (bit 0 low, bits 2..1 channel number, A=0 to D=3) stores `din[7:0]` into bits 7..0 of that channel's input register.
- R2: A write at address `{ch,1}` stores `din[3:0]` into bits 11..8 of that channel's input register; `din[7:4]` has no effect on any code.
- R3: An input register half changes only on the synchronised rising edge of `wr_n` while `cs_n` is low. No other half and no other channel changes.
- R4: With `cs_n` low, `wr_n` high and `le_n` low, all four output codes load from the input registers on one and the same clock.
- R5: With `cs_n`, `wr_n` and `le_n` all low, the output codes follow the data being written without a separate load step.
- R6: While `cs_n` is high, or while `le_n` and `wr_n` are both high, no output code changes. A write strobe with `cs_n` high leaves the input registers unchanged.
- R7: While `clr_n` is low, every output code is 800h, without waiting for a clock edge, and every input register is 000h.
- R8: A load after a clear drives 000h (negative full scale) on all four outputs.
- R9: `upd_o` is high for exactly those clock cycles in which `codes_o` took a new value.
- R10: `codes_o` packs channel A in bits 11..0, B in 23..12, C in 35..24 and D in 47..36. All codes are offset binary: FFFh is positive full scale, 800h is zero, 7FFh is one LSB below zero and 000h is negative full scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Port select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low; data captured on its return high |
| le_n | input | 1 | Latch enable for the output rank, active low |
| addr | input | 3 | Selects the channel (bits 2..1) and the half (bit 0) |
| din | input | 8 | Write data |
| codes_o | output | 48 | Four 12-bit offset-binary channel codes |
| upd_o | output | 1 | One-cycle pulse on each output code change |

## Verification
The assertions assume that `addr` and `din` stay stable from before `wr_n` falls until several clocks after it returns high. They also assume that strobe pulses last longer than the synchroniser delay, so that each pulse is seen as one level change. The bench holds address and data across its whole write task and keeps every strobe level for at least four clocks. It changes `cs_n` and `le_n` only together or while `wr_n` is high, so no unseen glitch reaches the synchronised controls. Random writes, ignored writes and loads mix with directed clears issued between clock edges.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned LO_W   = BUS_W;
  localparam int unsigned HI_W   = CODE_W - BUS_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [BUS_W-1:0]  bus_t;

  // Mid-scale code: zero output in offset binary
  localparam code_t MID_CODE = code_t'(1) << (CODE_W - 1);

  typedef enum logic [1:0] {OM_HOLD, OM_LOAD, OM_THRU} out_mode_e;

  // Replace one half of a channel word with bus data
  function automatic code_t merge_half(code_t cur, logic hi_sel, bus_t d);
    code_t r;
    r = cur;
    if (hi_sel) r[CODE_W-1:LO_W] = d[HI_W-1:0];
    else        r[LO_W-1:0]      = d;
    return r;
  endfunction

  // Output rank behaviour from the synchronised active-low controls
  function automatic out_mode_e decode_mode(logic cs_q, logic wr_q, logic le_q);
    if (cs_q || le_q) return OM_HOLD;
    return wr_q ? OM_LOAD : OM_THRU;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  // Controls are active low: reset to the inactive level
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_bus_front.sv
module qdac_bus_front import qdac_pkg::*; #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 3
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_q,
  input  logic              wr_q,
  input  logic [AW-1:0]     addr,
  input  bus_t              din,
  output logic [AW-1:0]     stg_addr,
  output bus_t              stg_data,
  output logic              wr_evt,
  output logic [2*NCH-1:0]  we_vec
);
  localparam int unsigned NHALF = 2 * NCH;

  logic wr_d;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      wr_d     <= 1'b1;
      stg_addr <= '0;
      stg_data <= '0;
    end else begin
      wr_d <= wr_q;
      if (!cs_q && !wr_q) begin
        stg_addr <= addr;
        stg_data <= din;
      end
    end
  end

  // Write strobe returning high while selected
  assign wr_evt = wr_q && !wr_d && !cs_q;

  for (genvar h = 0; h < NHALF; h++) begin : g_we
    assign we_vec[h] = wr_evt && (stg_addr == AW'(h));
  end
endmodule

// File: rtl/qdac_in_rank.sv
module qdac_in_rank import qdac_pkg::*; #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 3
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [2*NCH-1:0]  we_vec,
  input  logic [AW-1:0]     stg_addr,
  input  bus_t              stg_data,
  output code_t [NCH-1:0]   in_cur,
  output code_t [NCH-1:0]   in_nxt,
  output code_t [NCH-1:0]   in_view
);
  localparam int unsigned CW = AW - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    code_t cur_r;
    code_t nxt_c;

    always_comb begin
      nxt_c = cur_r;
      if (we_vec[2*c])   nxt_c = merge_half(cur_r, 1'b0, stg_data);
      if (we_vec[2*c+1]) nxt_c = merge_half(cur_r, 1'b1, stg_data);
    end

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) cur_r <= '0;
      else        cur_r <= nxt_c;
    end

    assign in_cur[c]  = cur_r;
    assign in_nxt[c]  = nxt_c;
    // What this channel would hold if the pending half landed now
    assign in_view[c] = (stg_addr[AW-1:1] == CW'(c))
                        ? merge_half(cur_r, stg_addr[0], stg_data) : cur_r;
  end
endmodule

// File: rtl/qdac_out_rank.sv
module qdac_out_rank import qdac_pkg::*; #(
  parameter int unsigned NCH = 4
) (
  input  logic            clk,
  input  logic            clr_n,
  input  out_mode_e       mode,
  input  code_t [NCH-1:0] in_nxt,
  input  code_t [NCH-1:0] in_view,
  output code_t [NCH-1:0] codes,
  output logic            upd
);
  code_t [NCH-1:0] nxt;

  always_comb begin
    case (mode)
      OM_LOAD: nxt = in_nxt;
      OM_THRU: nxt = in_view;
      default: nxt = codes;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      codes <= {NCH{MID_CODE}};
      upd   <= 1'b0;
    end else begin
      codes <= nxt;
      upd   <= (nxt != codes);
    end
  end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend import qdac_pkg::*; #(
  parameter  int unsigned NCH         = 4,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW          = $clog2(NCH) + 1
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic                  le_n,
  input  logic [AW-1:0]         addr,
  input  logic [BUS_W-1:0]      din,
  output logic [NCH*CODE_W-1:0] codes_o,
  output logic                  upd_o
);
  logic [2:0] ctl_q;
  logic       cs_q, wr_q, le_q;

  qdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr_n(clr_n), .d({cs_n, wr_n, le_n}), .q(ctl_q)
  );
  assign cs_q = ctl_q[2];
  assign wr_q = ctl_q[1];
  assign le_q = ctl_q[0];

  logic [AW-1:0]    stg_addr;
  bus_t             stg_data;
  logic             wr_evt;
  logic [2*NCH-1:0] we_vec;

  qdac_bus_front #(.NCH(NCH), .AW(AW)) u_front (
    .clk(clk), .clr_n(clr_n), .cs_q(cs_q), .wr_q(wr_q),
    .addr(addr), .din(din), .stg_addr(stg_addr), .stg_data(stg_data),
    .wr_evt(wr_evt), .we_vec(we_vec)
  );

  code_t [NCH-1:0] in_cur, in_nxt, in_view, code_r;

  qdac_in_rank #(.NCH(NCH), .AW(AW)) u_in (
    .clk(clk), .clr_n(clr_n), .we_vec(we_vec), .stg_addr(stg_addr),
    .stg_data(stg_data), .in_cur(in_cur), .in_nxt(in_nxt), .in_view(in_view)
  );

  out_mode_e mode;
  assign mode = decode_mode(cs_q, wr_q, le_q);

  qdac_out_rank #(.NCH(NCH)) u_out (
    .clk(clk), .clr_n(clr_n), .mode(mode), .in_nxt(in_nxt),
    .in_view(in_view), .codes(code_r), .upd(upd_o)
  );

  logic [NCH*CODE_W-1:0] in_flat;
  assign in_flat = in_cur;
  assign codes_o = code_r;
endmodule

// File: rtl/qdac_frontend_chk.sv
module qdac_frontend_chk import qdac_pkg::*; #(
  parameter int unsigned NCH = 4
) (
  input logic                  clk,
  input logic                  clr_n,
  input logic                  cs_q,
  input logic                  wr_q,
  input logic                  le_q,
  input logic                  wr_evt,
  input logic [2*NCH-1:0]      we_vec,
  input logic [NCH*CODE_W-1:0] in_flat,
  input logic [NCH*CODE_W-1:0] codes_o,
  input logic                  upd_o
);
  localparam logic [NCH*CODE_W-1:0] ALL_MID = {NCH{MID_CODE}};

  // R7
  clr_preset_chk: assert property (@(posedge clk)
    !clr_n |-> (codes_o == ALL_MID) && (in_flat == '0));

  // R6
  cs_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    cs_q |=> $stable(codes_o) && $stable(in_flat));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (le_q && wr_q) |=> $stable(codes_o));

  // R4
  load_match_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_q && wr_q && !le_q) |=> (codes_o == in_flat));

  // R3
  in_write_only_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !wr_evt |=> $stable(in_flat));

  // R3
  one_half_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $onehot0(we_vec));

  // R9
  upd_track_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (codes_o != $past(codes_o)) == upd_o);
endmodule

bind quad_dac_frontend qdac_frontend_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .clr_n(clr_n), .cs_q(cs_q), .wr_q(wr_q), .le_q(le_q),
  .wr_evt(wr_evt), .we_vec(we_vec), .in_flat(in_flat),
  .codes_o(codes_o), .upd_o(upd_o)
);

// File: tb/quad_dac_frontend_tb_top.sv
module quad_dac_frontend_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        clr_n = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, le_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [47:0] codes_o;
  logic        upd_o;

  always #2 clk = ~clk;

  quad_dac_frontend dut_i (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .le_n(le_n),
    .addr(addr), .din(din), .codes_o(codes_o), .upd_o(upd_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] exp_in  [4];
  logic [11:0] exp_out [4];

  // Monitor for R9: code moves versus strobe pulses
  int chg_cnt = 0, upd_cnt = 0, mism = 0;
  logic [47:0] prev_codes = '0;
  always @(negedge clk) begin
    if (clr_n) begin
      if (codes_o != prev_codes) chg_cnt++;
      if (upd_o) upd_cnt++;
      if ((codes_o != prev_codes) != upd_o) mism++;
    end
    prev_codes = codes_o;
  end

  function automatic logic [11:0] put_half(logic [11:0] w, bit hi, logic [7:0] d);
    if (hi) return {d[3:0], w[7:0]};
    return {w[11:8], d};
  endfunction

  function automatic logic [47:0] pack_out();
    return {exp_out[3], exp_out[2], exp_out[1], exp_out[0]};
  endfunction

  task automatic chk(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_half(logic [2:0] a, logic [7:0] d, bit sel);
    addr = a; din = d; cs_n = ~sel;
    cyc(1); wr_n = 1'b0;
    cyc(5); wr_n = 1'b1;
    cyc(5); cs_n = 1'b1;
    cyc(1);
    if (sel) exp_in[a[2:1]] = put_half(exp_in[a[2:1]], a[0], d);
  endtask

  task automatic latch(bit sel);
    cs_n = ~sel; le_n = 1'b0;
    cyc(5); le_n = 1'b1;
    cyc(4); cs_n = 1'b1;
    cyc(1);
    if (sel) for (int c = 0; c < 4; c++) exp_out[c] = exp_in[c];
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int c0, u0;
    logic [47:0] hold;
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_out[c] = 12'h800; end

    // R7: clear between edges, outputs at mid-scale
    #1 clr_n = 1'b0;
    #0.5;
    chk(codes_o == pack_out(), "R7 async clear mid-scale", codes_o, pack_out());
    cyc(3);
    chk({47'd0, upd_o} == 48'd0, "R9 no strobe in clear", {47'd0, upd_o}, 48'd0);
    clr_n = 1'b1;
    cyc(3);

    // R8: load after clear gives negative full scale; R4 single update
    c0 = chg_cnt; u0 = upd_cnt;
    latch(1'b1);
    chk(codes_o == 48'd0, "R8 load after clear", codes_o, 48'd0);
    chk(chg_cnt - c0 == 1 && upd_cnt - u0 == 1, "R4 one simultaneous update",
        48'(chg_cnt - c0), 48'd1);

    // R1 R2 R3: fill all halves, high nibbles with junk upper bits
    wr_half(3'b000, 8'h3C, 1'b1);
    wr_half(3'b001, 8'hA9, 1'b1);
    wr_half(3'b010, 8'hFF, 1'b1);
    wr_half(3'b011, 8'h57, 1'b1);
    wr_half(3'b100, 8'h00, 1'b1);
    wr_half(3'b101, 8'hF8, 1'b1);
    wr_half(3'b110, 8'hFF, 1'b1);
    wr_half(3'b111, 8'h07, 1'b1);
    chk(codes_o == 48'd0, "R6 outputs hold while le high", codes_o, 48'd0);
    c0 = chg_cnt;
    latch(1'b1);
    chk(codes_o == 48'h7FF_800_7FF_93C, "R1 R2 byte and nibble assembly",
        codes_o, 48'h7FF_800_7FF_93C);
    chk(codes_o == pack_out(), "R10 channel packing", codes_o, pack_out());
    chk(chg_cnt - c0 == 1, "R4 all channels same cycle", 48'(chg_cnt - c0), 48'd1);

    // R3: one half rewritten, neighbours untouched
    wr_half(3'b100, 8'h12, 1'b1);
    latch(1'b1);
    chk(codes_o == pack_out(), "R3 only addressed half", codes_o, pack_out());
    // R2: upper data bits ignored on a high-nibble write
    wr_half(3'b101, 8'hF3, 1'b1);
    latch(1'b1);
    chk(codes_o[35:24] == 12'h312, "R2 upper data bits ignored",
        {36'd0, codes_o[35:24]}, 48'h312);

    // R6: write and load with select inactive change nothing
    hold = codes_o;
    wr_half(3'b000, 8'h55, 1'b0);
    latch(1'b0);
    chk(codes_o == hold, "R6 load with cs high", codes_o, hold);
    latch(1'b1);
    chk(codes_o == hold, "R6 write with cs high ignored", codes_o, hold);

    // R5: transparent output rank
    addr = 3'b110; din = 8'hA1; cs_n = 1'b0;
    cyc(1); le_n = 1'b0; wr_n = 1'b0;
    cyc(6);
    exp_in[3] = put_half(exp_in[3], 1'b0, 8'hA1);
    for (int c = 0; c < 4; c++) exp_out[c] = exp_in[c];
    chk(codes_o == pack_out(), "R5 transparent follows data", codes_o, pack_out());
    wr_n = 1'b1; cyc(5); le_n = 1'b1; cyc(4); cs_n = 1'b1; cyc(2);
    chk(codes_o == pack_out(), "R5 value kept after transparency", codes_o, pack_out());

    // Random mix of writes, ignored writes and loads
    for (int i = 0; i < 60; i++) begin
      int r;
      r = $urandom_range(7, 0);
      if (r < 5) wr_half(3'($urandom), 8'($urandom), r != 0);
      else begin
        latch(r != 5);
        chk(codes_o == pack_out(), "R4 random load", codes_o, pack_out());
      end
    end
    latch(1'b1);
    chk(codes_o == pack_out(), "R1 R2 random final load", codes_o, pack_out());

    // R7 R8: clear in the middle of a run, between edges
    #0.5 clr_n = 1'b0;
    #0.5;
    for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_out[c] = 12'h800; end
    chk(codes_o == pack_out(), "R7 clear before next edge", codes_o, pack_out());
    cyc(2); clr_n = 1'b1; cyc(3);
    latch(1'b1);
    chk(codes_o == 48'd0, "R8 negative full scale after clear", codes_o, 48'd0);

    // R9: strobe matched every code change
    cyc(3);
    chk(mism == 0 && chg_cnt == upd_cnt, "R9 strobe per change",
        48'(upd_cnt), 48'(chg_cnt));

    done = 1;
    finish_run();
  end
endmodule